// File: doc/BRIEF.md
# Segmented Current-Steering DAC Switch Decoder

This block sits between the sample bus and the switch array of a segmented current-steering converter. A 14-bit sample is captured on the rising clock edge. It is then split into three weight tiers. The upper five bits are decoded into a 31-wide thermometer code for the coarse unary cells. The next four bits are decoded into a 15-wide thermometer code for the fine unary cells; each fine cell carries one sixteenth of a coarse cell. The lowest five bits drive binary-weighted cells without decoding.

Each control comes with its own registered complement, so that every current cell is steered to exactly one of the two differential output nodes. All true and complementary controls are re-registered in a single output stage, so that every switch in the array toggles on the same edge. A sleep input freezes the output stage, so the switch pattern stays fixed while the converter is powered down.

Top module: `seg_dac_decoder`

## Requirements
- R1: A sample on `data_i` is captured at a rising edge of `clk_i`. Its decoded controls appear on the outputs after the following rising edge, which gives a latency of two edges.
- R2: With k = `data_i[13:9]`, bit i of `coarse_p_o` is 1 exactly when i < k. A value of 0 sets no bit and a value of 31 sets all 31 bits.
- R3: With m = `data_i[8:5]`, bit i of `fine_p_o` is 1 exactly when i < m. A value of 0 sets no bit and a value of 15 sets all 15 bits.
- R4: `lsb_p_o` equals `data_i[4:0]` bit for bit, and bit i carries binary weight 2^i.
- R5: Each `*_n_o` output is always the exact bitwise inverse of its `*_p_o` partner.
- R6: All true and complementary outputs change on the same clock edge. No output shows a partly updated code.
- R7: For every one of the 16384 input codes, 512·ones(`coarse_p_o`) + 32·ones(`fine_p_o`) + `lsb_p_o` equals the code sampled two edges earlier.
- R8: While `sleep_i` is 1 at a rising edge, the output registers keep their value and input changes have no effect on them. The input latch keeps sampling. At the first edge with `sleep_i` at 0, the outputs load the decode of the latched sample.
- R9: While `rst_ni` is 0, the latch is cleared and the outputs show the decode of code 0: every `*_p_o` bit is 0 and every `*_n_o` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Freeze output stage while high |
| data_i | input | 14 | Unsigned sample code |
| coarse_p_o | output | 31 | Coarse unary controls, steer to node A |
| coarse_n_o | output | 31 | Complements of coarse controls, steer to node B |
| fine_p_o | output | 15 | Fine unary controls, steer to node A |
| fine_n_o | output | 15 | Complements of fine controls |
| lsb_p_o | output | 5 | Binary-weighted controls, steer to node A |
| lsb_n_o | output | 5 | Complements of binary controls |

## Verification
Every one of the 16384 codes is streamed in order, one per clock. This covers each tier boundary, for example 511 to 512 and 15871 to 15872, where all fine and binary cells drop as one coarse cell switches on. Directed extremes are then applied: zero, full scale, and the single-tier values 0x3E00, 0x01E0 and 0x001F. These show whether each thermometer reaches its top bit without spilling into a neighbouring tier. Back-to-back random codes separate a correct two-edge latency from a one- or three-edge one, which a held code cannot do. Sleep windows with changing data show whether the output stage truly holds, and whether the first edge after release takes the latched sample.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  localparam int unsigned DEF_DATA_W   = 14;
  localparam int unsigned DEF_COARSE_W = 5;
  localparam int unsigned DEF_FINE_W   = 4;
endpackage

// File: rtl/seg_in_latch.sv
module seg_in_latch #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/seg_therm_dec.sv
module seg_therm_dec #(
  parameter int unsigned IN_W = 5,
  localparam int unsigned OUT_W = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  bin_i,
  output logic [OUT_W-1:0] therm_o
);
  for (genvar g = 0; g < OUT_W; g++) begin : g_cell
    assign therm_o[g] = (int'(bin_i) > g);
  end
endmodule

// File: rtl/seg_drive_reg.sv
// True/complement pair registered in one stage; complement from its own flops.
module seg_drive_reg #(
  parameter int unsigned W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] ctl_i,
  output logic [W-1:0] p_o,
  output logic [W-1:0] n_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_o <= '0;
      n_o <= '1;
    end else if (!hold_i) begin
      p_o <= ctl_i;
      n_o <= ~ctl_i;
    end
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder
  import seg_dac_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned COARSE_W = DEF_COARSE_W,
  parameter int unsigned FINE_W   = DEF_FINE_W,
  localparam int unsigned LSB_W    = DATA_W - COARSE_W - FINE_W,
  localparam int unsigned COARSE_N = (1 << COARSE_W) - 1,
  localparam int unsigned FINE_N   = (1 << FINE_W) - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sleep_i,
  input  logic [DATA_W-1:0]   data_i,
  output logic [COARSE_N-1:0] coarse_p_o,
  output logic [COARSE_N-1:0] coarse_n_o,
  output logic [FINE_N-1:0]   fine_p_o,
  output logic [FINE_N-1:0]   fine_n_o,
  output logic [LSB_W-1:0]    lsb_p_o,
  output logic [LSB_W-1:0]    lsb_n_o
);
  localparam int COARSE_WT = 1 << (FINE_W + LSB_W);
  localparam int FINE_WT   = 1 << LSB_W;

  logic [DATA_W-1:0]   lat_q;
  logic [COARSE_N-1:0] coarse_t;
  logic [FINE_N-1:0]   fine_t;

  seg_in_latch #(.W(DATA_W)) i_latch (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(data_i), .q_o(lat_q)
  );

  seg_therm_dec #(.IN_W(COARSE_W)) i_coarse_dec (
    .bin_i(lat_q[DATA_W-1 -: COARSE_W]), .therm_o(coarse_t)
  );

  seg_therm_dec #(.IN_W(FINE_W)) i_fine_dec (
    .bin_i(lat_q[LSB_W +: FINE_W]), .therm_o(fine_t)
  );

  seg_drive_reg #(.W(COARSE_N)) i_coarse_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(sleep_i),
    .ctl_i(coarse_t), .p_o(coarse_p_o), .n_o(coarse_n_o)
  );

  seg_drive_reg #(.W(FINE_N)) i_fine_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(sleep_i),
    .ctl_i(fine_t), .p_o(fine_p_o), .n_o(fine_n_o)
  );

  seg_drive_reg #(.W(LSB_W)) i_lsb_drv (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(sleep_i),
    .ctl_i(lat_q[LSB_W-1:0]), .p_o(lsb_p_o), .n_o(lsb_n_o)
  );

  // edges since reset, saturating; gates the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R5
  compl_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_n_o == ~coarse_p_o) && (fine_n_o == ~fine_p_o) && (lsb_n_o == ~lsb_p_o));

  // R2
  coarse_therm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_p_o & (coarse_p_o >> 1)) == (coarse_p_o >> 1));

  // R3
  fine_therm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fine_p_o & (fine_p_o >> 1)) == (fine_p_o >> 1));

  // R8
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(coarse_p_o) && $stable(fine_p_o) && $stable(lsb_p_o));

  // R1 R7
  weight_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q >= 2'd2 && !$past(sleep_i)) |->
      ($countones(coarse_p_o) * COARSE_WT + $countones(fine_p_o) * FINE_WT
       + int'(lsb_p_o)) == int'($past(data_i, 2)));
endmodule

// File: tb/test_seg_dac_decoder.sv
module test_seg_dac_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sleep_i = 1'b0;
  logic [13:0] data_i = '0;
  logic [30:0] coarse_p_o, coarse_n_o;
  logic [14:0] fine_p_o, fine_n_o;
  logic [4:0]  lsb_p_o, lsb_n_o;

  int n_chk = 0;
  int n_bad = 0;

  seg_dac_decoder i_seg_dac_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .data_i(data_i),
    .coarse_p_o(coarse_p_o), .coarse_n_o(coarse_n_o),
    .fine_p_o(fine_p_o), .fine_n_o(fine_n_o),
    .lsb_p_o(lsb_p_o), .lsb_n_o(lsb_n_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [30:0] exp_coarse(input logic [4:0] k);
    logic [30:0] r = '0;
    for (int i = 0; i < 31; i++) r[i] = (i < int'(k));
    return r;
  endfunction

  function automatic logic [14:0] exp_fine(input logic [3:0] m);
    logic [14:0] r = '0;
    for (int i = 0; i < 15; i++) r[i] = (i < int'(m));
    return r;
  endfunction

  task automatic check(input logic [13:0] code, input string req);
    logic [30:0] ec;
    logic [14:0] ef;
    int sum;
    ec = exp_coarse(code[13:9]);
    ef = exp_fine(code[8:5]);
    n_chk++;
    if (coarse_p_o !== ec || fine_p_o !== ef || lsb_p_o !== code[4:0]) begin
      n_bad++;
      $display("FAIL %s R2/R3/R4 code=%h: got c=%h f=%h l=%h exp c=%h f=%h l=%h",
               req, code, coarse_p_o, fine_p_o, lsb_p_o, ec, ef, code[4:0]);
    end
    n_chk++;
    if (coarse_n_o !== ~coarse_p_o || fine_n_o !== ~fine_p_o || lsb_n_o !== ~lsb_p_o) begin
      n_bad++;
      $display("FAIL R5 code=%h: got n c=%h f=%h l=%h exp c=%h f=%h l=%h", code,
               coarse_n_o, fine_n_o, lsb_n_o, ~coarse_p_o, ~fine_p_o, ~lsb_p_o);
    end
    sum = $countones(coarse_p_o) * 512 + $countones(fine_p_o) * 32 + int'(lsb_p_o);
    n_chk++;
    if (sum != int'(code)) begin
      n_bad++;
      $display("FAIL R7 weighted sum: got %0d exp %0d", sum, code);
    end
  endtask

  // stream codes one per clock; output at negedge j shows code from j-2 (R1, R6)
  logic [13:0] h1, h2;
  int          hn;

  task automatic push(input logic [13:0] code, input string req);
    @(negedge clk_i);
    if (hn >= 2) check(h2, req);
    h2 = h1;
    h1 = code;
    hn++;
    data_i = code;
  endtask

  task automatic flush(input string req);
    push(data_i, req);
    push(data_i, req);
    hn = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [13:0] held, other;
    void'($urandom(32'h5eed_d0c0));
    hn = 0;
    h1 = '0;
    h2 = '0;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    check(14'h0000, "R9");
    data_i = 14'h3FFF;
    @(negedge clk_i);
    check(14'h0000, "R9 during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    hn = 0;

    // R7 exhaustive streaming walk
    for (int c = 0; c < 16384; c++) push(14'(c), "R7 R1");
    flush("R7");

    // R2 R3 R4 directed extremes
    push(14'h0000, "R2 R3 R4 zero");
    push(14'h3FFF, "R2 R3 R4 full");
    push(14'h3E00, "R2 coarse only");
    push(14'h01E0, "R3 fine only");
    push(14'h001F, "R4 lsb only");
    push(14'h0200, "R2 one coarse");
    push(14'h01FF, "R3 R4 below coarse");
    push(14'h0020, "R3 one fine");
    flush("R6");

    // R1 R6 random back-to-back
    for (int j = 0; j < 4000; j++) push(14'($urandom()), "R1 R6 random");
    flush("R1");

    // R8 sleep windows
    for (int t = 0; t < 20; t++) begin
      held  = 14'($urandom());
      other = ~held;
      @(negedge clk_i); data_i = held;
      @(negedge clk_i);
      @(negedge clk_i);
      check(held, "R8 pre-sleep");
      sleep_i = 1'b1;
      data_i  = other;
      for (int s = 0; s < 5; s++) begin
        @(negedge clk_i);
        check(held, "R8 holding");
        data_i = 14'($urandom());
      end
      data_i = other;
      @(negedge clk_i);
      check(held, "R8 holding last");
      sleep_i = 1'b0;
      @(negedge clk_i);
      check(other, "R8 release");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule